// File: doc/BRIEF.md
# Multiplexed-Bus Register Port for a Real-Time Clock

This block is the slave side of a clock chip's host interface. The host uses a shared 8-bit address/data bus. A pulse on the address strobe carries a 7-bit address, and the block keeps it as the current location. Chip-select and separate active-low read and write strobes then move one byte to or from that location.

The 128-location space has two parts. The fourteen lowest locations hold the clock, alarm and control bytes. The remaining 114 locations are general-purpose storage. The timekeeping and interrupt logic live elsewhere. They see this block only through hook ports: the two status bytes that come back on reads, the two control bytes that go out, and a one-cycle pulse that tells the interrupt logic its status byte was read.

All strobes are asynchronous to the system clock. The block passes them through a two-flop synchronizer and acts on their synchronized edges. The output-enable is the exception: it is formed directly from the pins, so the bus is released the moment the read strobe goes high. A power-fail input and the reset input both lock the host out.

Top module: `mbus_reg_port`

## Requirements
- R1: On a synchronized falling edge of `asPin`, the block latches bits 6..0 of `busIn` as the current address and ignores bit 7. The address is held until the next such edge, so address 0x8E and address 0x0E select the same location.
- R2: A write stores the byte on `busIn` at the current address on the synchronized rising edge of `wrN`, provided chip-select is active. A later read returns the stored byte at every location from 0x00 to 0x0B and from 0x0E to 0x7F, subject to R4.
- R3: A read of location 0x0C returns the `statusC` input, and a read of 0x0D returns the `statusD` input. Writes to either location have no effect.
- R4: Bit 7 of location 0x00 and bit 7 of location 0x0A are read-only. A write replaces bits 6..0 and leaves bit 7 at its previous value.
- R5: While `csN` is high, the address strobe still latches an address, but no write is stored and `busOe` stays low.
- R6: `busOe` is high exactly while `csN` and `rdN` are both low, `pwrFail` is low and `rstN` is high. It drops in the same cycle that `rdN` rises. While it is high, `busOut` carries the byte at the current address.
- R7: While `pwrFail` is high, chip-select is treated as inactive: writes are dropped and `busOe` stays low.
- R8: While `rstN` is low, no write is stored, `busOe` is low and `regCReadPulse` is low.
- R9: Each read of location 0x0C with chip-select active raises `regCReadPulse` for exactly one clock cycle. A read of any other location raises no pulse.
- R10: `regAOut` and `regBOut` always show the stored bytes at locations 0x0A and 0x0B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; blocks all access while low |
| busIn | input | 8 | Shared bus as seen by the block (address, then data) |
| busOut | output | 8 | Read data toward the shared bus |
| busOe | output | 1 | High while the block drives the bus |
| asPin | input | 1 | Address strobe, active high; address taken on its fall |
| csN | input | 1 | Chip-select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low; commit on its rise |
| pwrFail | input | 1 | Power-fail indication; forces chip-select inactive |
| statusC | input | 8 | Interrupt status byte returned at 0x0C |
| statusD | input | 8 | Validity byte returned at 0x0D |
| regAOut | output | 8 | Stored byte at 0x0A (rate select hook) |
| regBOut | output | 8 | Stored byte at 0x0B (mode control hook) |
| regCReadPulse | output | 1 | One-cycle pulse when 0x0C is read |

## Verification
The falling edge of the address strobe and the rising edge of the write strobe can be detected in the same clock cycle. In that case the write must go to the address that was current before the edge, while the new bus value becomes the next address. The bench provokes this by holding a write open, raising the address strobe with a new value on the bus, and then releasing the address strobe and the write strobe at the same instant. It judges the result by reading, with no new address, the location whose contents were preset earlier, and then reading back the old location to find the bus value stored there.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] ADDR_SEC  = 7'h00;
  localparam logic [ADDR_W-1:0] ADDR_REGA = 7'h0A;
  localparam logic [ADDR_W-1:0] ADDR_REGB = 7'h0B;
  localparam logic [ADDR_W-1:0] ADDR_REGC = 7'h0C;
  localparam logic [ADDR_W-1:0] ADDR_REGD = 7'h0D;

  typedef struct packed {
    logic latchAddr;
    logic commitWr;
    logic readC;
  } strobe_t;
endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    asPin,
  input  logic    csN,
  input  logic    rdN,
  input  logic    wrN,
  input  logic    pwrFail,
  input  logic    isRegC,
  output strobe_t strb
);
  localparam int LAST = STAGES;
  localparam int NOW  = STAGES - 1;

  logic [STAGES:0] asSh;
  logic [STAGES:0] selSh;
  logic [STAGES:0] rdSh;
  logic [STAGES:0] wrSh;
  logic selRaw;

  assign selRaw = ~csN & ~pwrFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asSh  <= '0;
      selSh <= '0;
      rdSh  <= '0;
      wrSh  <= '0;
    end else begin
      asSh  <= {asSh[STAGES-1:0], asPin};
      selSh <= {selSh[STAGES-1:0], selRaw};
      rdSh  <= {rdSh[STAGES-1:0], ~rdN};
      wrSh  <= {wrSh[STAGES-1:0], ~wrN};
    end
  end

  always_comb begin
    strb.latchAddr = asSh[LAST] & ~asSh[NOW];
    strb.commitWr  = wrSh[LAST] & ~wrSh[NOW] & selSh[NOW];
    strb.readC     = rdSh[NOW] & ~rdSh[LAST] & selSh[NOW] & isRegC;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.readC |=> !strb.readC); // R9
endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] busIn,
  input  strobe_t       strb,
  input  logic [DW-1:0] statusC,
  input  logic [DW-1:0] statusD,
  output logic [DW-1:0] rdData,
  output logic          isRegC,
  output logic [DW-1:0] regAOut,
  output logic [DW-1:0] regBOut
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] busSh [STAGES];
  logic [AW-1:0] addrLat;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wrByte;
  logic          roByte;
  logic          msbKeep;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) busSh[g] <= '0;
          else       busSh[g] <= busIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) busSh[g] <= '0;
          else       busSh[g] <= busSh[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrLat <= '0;
    else if (strb.latchAddr) addrLat <= busSh[STAGES-1][AW-1:0];
  end

  assign roByte  = (addrLat == ADDR_REGC) || (addrLat == ADDR_REGD);
  assign msbKeep = (addrLat == ADDR_SEC) || (addrLat == ADDR_REGA);

  always_comb begin
    wrByte = busSh[STAGES-1];
    if (msbKeep) wrByte[DW-1] = mem[addrLat][DW-1];
  end

  always_ff @(posedge clk) begin
    if (rstN && strb.commitWr && !roByte) mem[addrLat] <= wrByte;
  end

  always_comb begin
    if (addrLat == ADDR_REGC)      rdData = statusC;
    else if (addrLat == ADDR_REGD) rdData = statusD;
    else                           rdData = mem[addrLat];
  end

  assign isRegC  = (addrLat == ADDR_REGC);
  assign regAOut = mem[ADDR_REGA];
  assign regBOut = mem[ADDR_REGB];

  AST_PULSE_AT_C: assert property (@(posedge clk) disable iff (!rstN)
    strb.readC |-> addrLat == ADDR_REGC); // R9
  AST_SEC_MSB_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWr && addrLat == ADDR_SEC) |=> mem[ADDR_SEC][DW-1] == $past(mem[ADDR_SEC][DW-1])); // R4
  AST_REGA_MSB_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWr && addrLat == ADDR_REGA) |=> regAOut[DW-1] == $past(regAOut[DW-1])); // R4
endmodule

// File: rtl/mbus_reg_port.sv
module mbus_reg_port
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busOe,
  input  logic       asPin,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       pwrFail,
  input  logic [7:0] statusC,
  input  logic [7:0] statusD,
  output logic [7:0] regAOut,
  output logic [7:0] regBOut,
  output logic       regCReadPulse
);
  strobe_t    strb;
  logic       isRegC;
  logic [7:0] rdData;

  mbus_ctrl #(.STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .asPin(asPin), .csN(csN), .rdN(rdN), .wrN(wrN),
    .pwrFail(pwrFail), .isRegC(isRegC), .strb(strb)
  );

  mbus_dp #(.AW(ADDR_W), .DW(DATA_W), .STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .strb(strb), .statusC(statusC),
    .statusD(statusD), .rdData(rdData), .isRegC(isRegC), .regAOut(regAOut),
    .regBOut(regBOut)
  );

  assign busOe         = rstN & ~csN & ~rdN & ~pwrFail;
  assign busOut        = busOe ? rdData : '0;
  assign regCReadPulse = strb.readC;

  AST_OE_NEEDS_SEL: assert property (@(posedge clk)
    busOe |-> (!csN && !rdN && !pwrFail)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!busOe && !regCReadPulse)); // R8
  AST_PWRFAIL_NO_OE: assert property (@(posedge clk)
    pwrFail |-> !busOe); // R7
endmodule

// File: tb/mbus_reg_port_test.sv
module mbus_reg_port_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] busIn = 0;
  logic [7:0] busOut;
  logic       busOe;
  logic       asPin = 0, csN = 1, rdN = 1, wrN = 1, pwrFail = 0;
  logic [7:0] statusC = 8'hC3, statusD = 8'h80;
  logic [7:0] regAOut, regBOut;
  logic       regCReadPulse;

  int checks = 0, failures = 0, pulseCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbus_reg_port uut (.*);

  always @(posedge clk) if (regCReadPulse) pulseCnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latchAddr(input logic [7:0] a);
    @(negedge clk) busIn = a; asPin = 1;
    repeat (3) @(negedge clk);
    asPin = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic writeCur(input logic [7:0] d, input logic cs);
    busIn = d; csN = cs;
    repeat (2) @(negedge clk);
    wrN = 0;
    repeat (4) @(negedge clk);
    wrN = 1;
    repeat (4) @(negedge clk);
    csN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    latchAddr(a); writeCur(d, 1'b0);
  endtask

  task automatic readCur(output logic [7:0] v, output logic oe, input string req);
    @(negedge clk) csN = 0;
    @(negedge clk) rdN = 0;
    repeat (3) @(negedge clk);
    #1 oe = busOe; v = busOut;
    @(negedge clk) rdN = 1;
    #1 check({req, " release"}, busOe, 0);
    repeat (4) @(negedge clk);
    csN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic readChk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v; logic oe;
    latchAddr(a); readCur(v, oe, req);
    check({req, " oe"}, oe, 1);
    check(req, v, exp);
  endtask

  task automatic testReset();
    csN = 0; rdN = 0; #1;
    check("R8 oe in reset", busOe, 0);
    check("R8 pulse in reset", regCReadPulse, 0);
    csN = 1; rdN = 1;
    rstN = 1; repeat (3) @(negedge clk);
    doWrite(8'h20, 8'h11);
    rstN = 0;
    doWrite(8'h20, 8'h99);
    rstN = 1; repeat (3) @(negedge clk);
    readChk(8'h20, 8'h11, "R8 write in reset dropped");
  endtask

  task automatic testRam();
    doWrite(8'h0E, 8'h5A); doWrite(8'h7F, 8'hA5); doWrite(8'h05, 8'h3C);
    readChk(8'h0E, 8'h5A, "R2 ram low");
    readChk(8'h7F, 8'hA5, "R2 ram top");
    readChk(8'h05, 8'h3C, "R2 alarm byte");
    readChk(8'h8E, 8'h5A, "R1 addr bit7 ignored");
  endtask

  task automatic testReadOnly();
    logic [7:0] v; logic oe;
    doWrite(8'h0C, 8'h00); doWrite(8'h0D, 8'h55);
    readChk(8'h0C, 8'hC3, "R3 reg C");
    readChk(8'h0D, 8'h80, "R3 reg D");
    latchAddr(8'h00); readCur(v, oe, "R4 sec pre");
    writeCur(8'hFF, 1'b0);
    readChk(8'h00, {v[7], 7'h7F}, "R4 sec msb kept");
    latchAddr(8'h0A); readCur(v, oe, "R4 regA pre");
    writeCur(8'hAA, 1'b0);
    readChk(8'h0A, {v[7], 7'h2A}, "R4 regA msb kept");
    check("R10 regAOut", regAOut, {v[7], 7'h2A});
    doWrite(8'h0B, 8'h96);
    check("R10 regBOut", regBOut, 8'h96);
  endtask

  task automatic testNoSelect();
    logic [7:0] v; logic oe;
    doWrite(8'h40, 8'h12); doWrite(8'h41, 8'h34);
    latchAddr(8'h41);
    writeCur(8'hEE, 1'b1);
    readCur(v, oe, "R5");
    check("R5 cs high address still latched", v, 8'h34);
    @(negedge clk) rdN = 0; #1;
    check("R5 oe with cs high", busOe, 0);
    rdN = 1; csN = 0; #1;
    check("R6 oe with rd high", busOe, 0);
    csN = 1;
  endtask

  task automatic testPwrFail();
    logic [7:0] v; logic oe;
    doWrite(8'h21, 8'h11);
    pwrFail = 1;
    doWrite(8'h21, 8'h99);
    latchAddr(8'h21); readCur(v, oe, "R7");
    check("R7 oe in power fail", oe, 0);
    pwrFail = 0;
    readChk(8'h21, 8'h11, "R7 write dropped");
  endtask

  task automatic testPulse();
    int base;
    base = pulseCnt;
    readChk(8'h0C, 8'hC3, "R9 read C");
    check("R9 one pulse", pulseCnt - base, 1);
    base = pulseCnt;
    readChk(8'h0D, 8'h80, "R9 read D");
    check("R9 no pulse on D", pulseCnt - base, 0);
  endtask

  task automatic testCollide();
    logic [7:0] v; logic oe;
    doWrite(8'h45, 8'h5A);
    latchAddr(8'h30);
    busIn = 8'h77; csN = 0;
    @(negedge clk) wrN = 0;
    repeat (2) @(negedge clk);
    busIn = 8'h45; asPin = 1;
    repeat (3) @(negedge clk);
    asPin = 0; wrN = 1;
    repeat (4) @(negedge clk);
    csN = 1; repeat (2) @(negedge clk);
    readCur(v, oe, "R1 collide");
    check("R1 collide new address", v, 8'h5A);
    readChk(8'h30, 8'h45, "R2 collide old address written");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testRam();
    testReadOnly();
    testNoSelect();
    testPwrFail();
    testPulse();
    testCollide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule